// File: doc/BRIEF.md
# On-Chip Backpropagation Trainer for a Four-Input Perceptron Network

This block is a small multilayer perceptron that learns in hardware. Four signed fixed-point inputs feed a hidden layer of four nodes. Every input reaches every hidden node through its own weight. The hidden nodes feed one output node through their own weights. Each node applies a saturating piecewise-linear sigmoid to its weighted sum. The output value lies between 0 and 1 and is also given as a yes/no decision.

A caller presents the four inputs, a target value, a learning-rate shift and a mode, and raises `start_i` while the engine is idle. In training mode the engine works through a fixed schedule of eleven one-step-per-clock operations. The schedule runs the forward pass, forms the squared output error, adds that error to a running total, and then updates both weight matrices by backpropagation. In inference mode the engine stops after the four forward steps and leaves all weights untouched. Either mode ends with a one-cycle `done_o` pulse. The weights are held in internal registers. A synchronous load port writes their initial values while the engine is idle.

All arithmetic uses 32-bit two's-complement words with 16 fraction bits. Additions wrap. Products are formed at full width, shifted right by 16 and clamped to the word range.

Top module: `mlp_trainer`

## Requirements
- R1: Values are 32-bit signed words with 16 fraction bits (1.0 = 65536). Sums and differences wrap as plain 32-bit integers. A product is the 64-bit product shifted arithmetically right by 16 and then clamped to the range from -2^31 to 2^31-1.
- R2: The forward pass works in three stages. Hidden sum h = Σ_i W1[h][i]·x[i]. Hidden output a[h] = sig(sum). Output y = sig(Σ_h W2[h]·a[h]). `y_o` shows y once the forward pass has run, and `decision_o` is 1 exactly when `y_o` ≥ 32768 (0.5).
- R3: sig(z) = 0 for z < -262144 (-4.0), 65536 for z > 262144 (+4.0), and 32768 + (z >>> 3) otherwise.
- R4: In training mode (`train_i`=1), `done_o` rises 11 clock edges after the edge that accepts `start_i`.
- R5: In inference mode (`train_i`=0), `done_o` rises 4 edges after acceptance. The weights, `sq_err_o` and `err_sum_o` stay unchanged.
- R6: In a training step, e = y - target. `sq_err_o` becomes mul(e,e), and `err_sum_o` adds that value to its previous content with a wrapping add.
- R7: A training step applies these updates. g = mul(e, mul(y, 1-y)). d[h] = mul(mul(g, W2[h]), mul(a[h], 1-a[h])), using the old W2. Then W2[h] -= mul(g, a[h]) >>> s and W1[h][i] -= mul(d[h], x[i]) >>> s.
- R8: The shift s is `lr_shift_i`, captured at acceptance. It acts as an arithmetic right shift (learning rate 2^-s).
- R9: `start_i` is accepted only while the engine is idle. A start raised during a run changes neither the result nor the timing of that run, and it does not queue a second run.
- R10: Load address a in 0..15 writes W1[a/4][a%4], and 16..19 writes W2[a-16]. A load is taken only while idle. Loads while busy and loads to addresses 20..31 are ignored.
- R11: Reset clears `y_o`, `sq_err_o`, `err_sum_o` and `done_o` to 0 and sets every weight to the parameter `W_RESET` (default 0). An inference after reset with the default value therefore gives y = 32768.
- R12: `done_o` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a run; sampled while idle |
| train_i | input | 1 | 1 = training run, 0 = inference run |
| x_i | input | 128 | Four input values, input i at bits [32i+31:32i] |
| target_i | input | 32 | Target output for training |
| lr_shift_i | input | 4 | Learning-rate right shift |
| load_en_i | input | 1 | Weight write strobe |
| load_addr_i | input | 5 | Weight index (see R10) |
| load_data_i | input | 32 | Weight value to write |
| done_o | output | 1 | One-cycle end-of-run pulse |
| y_o | output | 32 | Network output |
| decision_o | output | 1 | Yes/no reading of `y_o` |
| sq_err_o | output | 32 | Squared error of the last training example |
| err_sum_o | output | 32 | Running total of squared errors |

## Verification
The properties take several things for granted. `start_i` may arrive at any time, including mid-run, and loads may target any address. They also rely on the sigmoid keeping `y_o` inside 0..1 whatever the weights are. The bench keeps targets at 0 or 1.0, so e stays within ±1.0 and the squared error does not clamp. It draws weights within ±1.0 and inputs within ±2.0, and it reaches the clamping and sigmoid knees only through chosen directed weights. Mid-run starts and loads are issued on purpose to show that the engine ignores them.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
    localparam int FX_W    = 32;
    localparam int FX_FRAC = 16;
    localparam int N_IN    = 4;
    localparam int N_HID   = 4;
    localparam int LR_W    = 4;
    localparam int N_W1    = N_IN * N_HID;
    localparam int N_WT    = N_W1 + N_HID;
    localparam int ADDR_W  = $clog2(N_WT);
    localparam int STEP_W  = 4;

    typedef logic signed [FX_W-1:0] fx_t;

    localparam fx_t FX_ONE  = fx_t'(64'sd1 <<< FX_FRAC);
    localparam fx_t FX_HALF = FX_ONE >>> 1;
    localparam fx_t FX_MAX  = {1'b0, {(FX_W-1){1'b1}}};
    localparam fx_t FX_MIN  = {1'b1, {(FX_W-1){1'b0}}};
    localparam fx_t SIG_HI  = fx_t'(64'sd4 <<< FX_FRAC);
    localparam fx_t SIG_LO  = -SIG_HI;

    // schedule steps, one per clock
    localparam logic [STEP_W-1:0] ST_HSUM  = 4'd0;
    localparam logic [STEP_W-1:0] ST_HACT  = 4'd1;
    localparam logic [STEP_W-1:0] ST_OSUM  = 4'd2;
    localparam logic [STEP_W-1:0] ST_OACT  = 4'd3;
    localparam logic [STEP_W-1:0] ST_ERR   = 4'd4;
    localparam logic [STEP_W-1:0] ST_ODER  = 4'd5;
    localparam logic [STEP_W-1:0] ST_ODEL  = 4'd6;
    localparam logic [STEP_W-1:0] ST_HDER  = 4'd7;
    localparam logic [STEP_W-1:0] ST_HDEL  = 4'd8;
    localparam logic [STEP_W-1:0] ST_UPD2  = 4'd9;
    localparam logic [STEP_W-1:0] ST_UPD1  = 4'd10;

    localparam logic [STEP_W-1:0] ST_LAST_INFER = ST_OACT;
    localparam logic [STEP_W-1:0] ST_LAST_TRAIN = ST_UPD1;

    // saturating fixed-point product
    function automatic fx_t fx_mul(fx_t a, fx_t b);
        logic signed [2*FX_W-1:0] wa, wb, p, lim_hi, lim_lo;
        wa = a;
        wb = b;
        lim_hi = FX_MAX;
        lim_lo = FX_MIN;
        p = (wa * wb) >>> FX_FRAC;
        if (p > lim_hi)      return FX_MAX;
        else if (p < lim_lo) return FX_MIN;
        else                 return p[FX_W-1:0];
    endfunction

    // piecewise-linear logistic approximation
    function automatic fx_t fx_sig(fx_t z);
        if (z < SIG_LO)      return '0;
        else if (z > SIG_HI) return FX_ONE;
        else                 return FX_HALF + (z >>> 3);
    endfunction
endpackage

// File: rtl/mlp_dot.sv
module mlp_dot
    import mlp_pkg::*;
#(
    parameter int N = 4
) (
    input  fx_t [N-1:0] a,
    input  fx_t [N-1:0] b,
    output fx_t         sum
);
    always_comb begin
        sum = '0;
        for (int k = 0; k < N; k++) begin
            sum = sum + fx_mul(a[k], b[k]);
        end
    end
endmodule

// File: rtl/mlp_seq.sv
module mlp_seq
    import mlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              train,
    output logic              accept,
    output logic              busy,
    output logic              train_q,
    output logic [STEP_W-1:0] step,
    output logic              done
);
    typedef struct packed {
        logic              busy;
        logic              train;
        logic [STEP_W-1:0] step;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [STEP_W-1:0] last_step;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        accept     = !seq_q.busy && start;
        last_step  = seq_q.train ? ST_LAST_TRAIN : ST_LAST_INFER;
        if (accept) begin
            seq_d.busy  = 1'b1;
            seq_d.train = train;
            seq_d.step  = '0;
        end else if (seq_q.busy) begin
            if (seq_q.step == last_step) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                seq_d.step = '0;
            end else begin
                seq_d.step = seq_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy    = seq_q.busy;
    assign train_q = seq_q.train;
    assign step    = seq_q.step;
    assign done    = seq_q.done;
endmodule

// File: rtl/mlp_trainer.sv
module mlp_trainer
    import mlp_pkg::*;
#(
    parameter fx_t W_RESET = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   train_i,
    input  logic [N_IN*FX_W-1:0]   x_i,
    input  logic [FX_W-1:0]        target_i,
    input  logic [LR_W-1:0]        lr_shift_i,
    input  logic                   load_en_i,
    input  logic [ADDR_W-1:0]      load_addr_i,
    input  logic [FX_W-1:0]        load_data_i,
    output logic                   done_o,
    output logic [FX_W-1:0]        y_o,
    output logic                   decision_o,
    output logic [FX_W-1:0]        sq_err_o,
    output logic [FX_W-1:0]        err_sum_o
);
    typedef struct packed {
        fx_t [N_IN-1:0]  x;
        fx_t             t;
        logic [LR_W-1:0] lr;
        fx_t [N_W1-1:0]  w1;
        fx_t [N_HID-1:0] w2;
        fx_t [N_HID-1:0] hsum;
        fx_t [N_HID-1:0] hout;
        fx_t [N_HID-1:0] hder;
        fx_t [N_HID-1:0] hdel;
        fx_t             zo;
        fx_t             y;
        fx_t             e;
        fx_t             yder;
        fx_t             odel;
        fx_t             sq;
        fx_t             esum;
    } dp_t;

    dp_t dp_d, dp_q;

    logic              accept, busy, train_q, done;
    logic [STEP_W-1:0] step;
    fx_t [N_HID-1:0]   row_sum;
    fx_t               out_sum;
    fx_t               err_c;

    mlp_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_i),
        .train  (train_i),
        .accept (accept),
        .busy   (busy),
        .train_q(train_q),
        .step   (step),
        .done   (done)
    );

    for (genvar h = 0; h < N_HID; h++) begin : g_row
        mlp_dot #(.N(N_IN)) u_row (
            .a  (dp_q.w1[h*N_IN +: N_IN]),
            .b  (dp_q.x),
            .sum(row_sum[h])
        );
    end

    mlp_dot #(.N(N_HID)) u_out (
        .a  (dp_q.w2),
        .b  (dp_q.hout),
        .sum(out_sum)
    );

    always_comb begin
        dp_d  = dp_q;
        err_c = dp_q.y - dp_q.t;
        if (accept) begin
            dp_d.x  = x_i;
            dp_d.t  = target_i;
            dp_d.lr = lr_shift_i;
        end
        if (!busy && load_en_i) begin
            for (int k = 0; k < N_W1; k++) begin
                if (load_addr_i == ADDR_W'(k)) dp_d.w1[k] = load_data_i;
            end
            for (int k = 0; k < N_HID; k++) begin
                if (load_addr_i == ADDR_W'(N_W1 + k)) dp_d.w2[k] = load_data_i;
            end
        end
        if (busy) begin
            case (step)
                ST_HSUM: dp_d.hsum = row_sum;
                ST_HACT: for (int h = 0; h < N_HID; h++) dp_d.hout[h] = fx_sig(dp_q.hsum[h]);
                ST_OSUM: dp_d.zo = out_sum;
                ST_OACT: dp_d.y = fx_sig(dp_q.zo);
                ST_ERR: begin
                    dp_d.e    = err_c;
                    dp_d.sq   = fx_mul(err_c, err_c);
                    dp_d.esum = dp_q.esum + fx_mul(err_c, err_c);
                end
                ST_ODER: dp_d.yder = fx_mul(dp_q.y, FX_ONE - dp_q.y);
                ST_ODEL: dp_d.odel = fx_mul(dp_q.e, dp_q.yder);
                ST_HDER: for (int h = 0; h < N_HID; h++)
                    dp_d.hder[h] = fx_mul(dp_q.hout[h], FX_ONE - dp_q.hout[h]);
                ST_HDEL: for (int h = 0; h < N_HID; h++)
                    dp_d.hdel[h] = fx_mul(fx_mul(dp_q.odel, dp_q.w2[h]), dp_q.hder[h]);
                ST_UPD2: for (int h = 0; h < N_HID; h++)
                    dp_d.w2[h] = dp_q.w2[h] - (fx_mul(dp_q.odel, dp_q.hout[h]) >>> dp_q.lr);
                ST_UPD1: for (int h = 0; h < N_HID; h++) begin
                    for (int i = 0; i < N_IN; i++) begin
                        dp_d.w1[h*N_IN+i] = dp_q.w1[h*N_IN+i]
                                          - (fx_mul(dp_q.hdel[h], dp_q.x[i]) >>> dp_q.lr);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q    <= '0;
            dp_q.w1 <= {N_W1{W_RESET}};
            dp_q.w2 <= {N_HID{W_RESET}};
        end else begin
            dp_q <= dp_d;
        end
    end

    fx_t [N_W1-1:0]  w1_cur;
    fx_t [N_HID-1:0] w2_cur;
    assign w1_cur = dp_q.w1;
    assign w2_cur = dp_q.w2;

    assign done_o     = done;
    assign y_o        = dp_q.y;
    assign decision_o = (dp_q.y >= FX_HALF);
    assign sq_err_o   = dp_q.sq;
    assign err_sum_o  = dp_q.esum;
endmodule

// File: rtl/mlp_trainer_chk.sv
module mlp_trainer_chk
    import mlp_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            load_en_i,
    input logic            done_o,
    input logic [FX_W-1:0] y_o,
    input logic [FX_W-1:0] err_sum_o,
    input logic            busy,
    input logic            train_q,
    input fx_t [N_W1-1:0]  w1,
    input fx_t [N_HID-1:0] w2
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R12

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy)); // R4

    AST_Y_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(y_o) >= 0) && ($signed(y_o) <= FX_ONE)); // R3

    AST_INFER_KEEPS_W: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !train_q) |=> ($stable(w1) && $stable(w2))); // R5

    AST_IDLE_NO_LOAD_KEEPS_W: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_en_i) |=> ($stable(w1) && $stable(w2))); // R10

    AST_ERR_TRAIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && train_q) |=> $stable(err_sum_o)); // R6
endmodule

bind mlp_trainer mlp_trainer_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en_i(load_en_i),
    .done_o   (done_o),
    .y_o      (y_o),
    .err_sum_o(err_sum_o),
    .busy     (busy),
    .train_q  (train_q),
    .w1       (w1_cur),
    .w2       (w2_cur)
);

// File: tb/mlp_trainer_tb_top.sv
`timescale 1ns/1ps
module mlp_trainer_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         train_i = 1'b0;
    logic [127:0] x_i = '0;
    logic [31:0]  target_i = '0;
    logic [3:0]   lr_shift_i = '0;
    logic         load_en_i = 1'b0;
    logic [4:0]   load_addr_i = '0;
    logic [31:0]  load_data_i = '0;
    logic         done_o, decision_o;
    logic [31:0]  y_o, sq_err_o, err_sum_o;

    always #5 clk = ~clk;

    mlp_trainer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .train_i(train_i),
        .x_i(x_i), .target_i(target_i), .lr_shift_i(lr_shift_i),
        .load_en_i(load_en_i), .load_addr_i(load_addr_i), .load_data_i(load_data_i),
        .done_o(done_o), .y_o(y_o), .decision_o(decision_o),
        .sq_err_o(sq_err_o), .err_sum_o(err_sum_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int mw1 [16];
    int mw2 [4];
    int mh [4];
    int my, msq, mesum;
    int cur_x [4];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_mul(input int a, input int b);
        longint p;
        p = (longint'(a) * longint'(b)) >>> 16;
        if (p > 64'sd2147483647) return 32'sh7fffffff;
        if (p < -64'sd2147483648) return 32'sh80000000;
        return int'(p);
    endfunction

    function automatic int m_sig(input int z);
        if (z < -262144) return 0;
        if (z > 262144) return 65536;
        return 32768 + (z >>> 3);
    endfunction

    task automatic model_fwd();
        int s;
        for (int h = 0; h < 4; h++) begin
            s = 0;
            for (int i = 0; i < 4; i++) s += m_mul(mw1[h*4+i], cur_x[i]);
            mh[h] = m_sig(s);
        end
        s = 0;
        for (int h = 0; h < 4; h++) s += m_mul(mw2[h], mh[h]);
        my = m_sig(s);
    endtask

    task automatic model_train(input int t, input int lr);
        int e, g;
        int dh [4];
        e = my - t;
        msq = m_mul(e, e);
        mesum += msq;
        g = m_mul(e, m_mul(my, 65536 - my));
        for (int h = 0; h < 4; h++)
            dh[h] = m_mul(m_mul(g, mw2[h]), m_mul(mh[h], 65536 - mh[h]));
        for (int h = 0; h < 4; h++) mw2[h] -= (m_mul(g, mh[h]) >>> lr);
        for (int h = 0; h < 4; h++)
            for (int i = 0; i < 4; i++) mw1[h*4+i] -= (m_mul(dh[h], cur_x[i]) >>> lr);
    endtask

    task automatic load(input int addr, input int data);
        @(negedge clk);
        load_en_i = 1'b1; load_addr_i = 5'(addr); load_data_i = data;
        @(negedge clk);
        load_en_i = 1'b0;
        if (addr < 16) mw1[addr] = data;
        else if (addr < 20) mw2[addr-16] = data;
    endtask

    // one run; disturb raises start and a load while busy
    task automatic run(input bit tr, input int t, input int lr, input bit disturb, input string tag);
        int cyc;
        @(negedge clk);
        for (int i = 0; i < 4; i++) x_i[i*32 +: 32] = cur_x[i];
        start_i = 1'b1; train_i = tr; target_i = t; lr_shift_i = 4'(lr);
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 40) begin
            if (disturb && cyc == 3) begin
                start_i = 1'b1; train_i = !tr; x_i = {4{32'h0003_0000}}; target_i = 32'h0;
                load_en_i = 1'b1; load_addr_i = 5'd16; load_data_i = 32'h0008_0000;
            end
            if (disturb && cyc == 4) begin
                start_i = 1'b0; load_en_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        model_fwd();
        if (tr) model_train(t, lr);
        chk(cyc == (tr ? 12 : 5), tr ? "R4 latency" : "R5 latency", cyc, tr ? 12 : 5);
        chk(int'(y_o) == my, {tag, " R2 y"}, int'(y_o), my);
        chk(decision_o == (my >= 32768), "R2 decision", int'(decision_o), int'(my >= 32768));
        if (tr) chk(int'(sq_err_o) == msq, "R6 sq_err", int'(sq_err_o), msq);
        chk(int'(err_sum_o) == mesum, "R6 err_sum", int'(err_sum_o), mesum);
        @(negedge clk);
        chk(done_o == 1'b0, "R12 done width", int'(done_o), 0);
        if (disturb) begin
            for (int k = 0; k < 14; k++) begin
                if (done_o) chk(1'b0, "R9 no queued run", 1, 0);
                @(negedge clk);
            end
        end
    endtask

    task automatic rand_weights();
        for (int a = 0; a < 20; a++) load(a, int'($urandom_range(0, 131072)) - 65536);
    endtask

    task automatic rand_x();
        for (int i = 0; i < 4; i++) cur_x[i] = int'($urandom_range(0, 262144)) - 131072;
    endtask

    initial begin
        #(150000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 16; k++) mw1[k] = 0;
        for (int k = 0; k < 4; k++) mw2[k] = 0;
        mesum = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(done_o == 1'b0, "R11 done", int'(done_o), 0);
        chk(y_o == 0, "R11 y", int'(y_o), 0);
        chk(sq_err_o == 0 && err_sum_o == 0, "R11 errors", int'(err_sum_o), 0);
        rand_x();
        run(1'b0, 0, 0, 1'b0, "R11 zero weights");
        chk(int'(y_o) == 32768, "R11 zero-weight output", int'(y_o), 32768);

        // R3 sigmoid knees, R1 saturation: single path x0 -> h0 -> y
        for (int a = 0; a < 20; a++) load(a, 0);
        load(0, 65536);
        load(16, 65536);
        cur_x = '{-327680, 0, 0, 0};
        run(1'b0, 0, 0, 1'b0, "R3");
        chk(int'(y_o) == 32768, "R3 low clamp", int'(y_o), 32768);
        cur_x = '{0, 0, 0, 0};
        run(1'b0, 0, 0, 1'b0, "R3");
        chk(int'(y_o) == 36864, "R3 centre", int'(y_o), 36864);
        cur_x = '{131072, 0, 0, 0};
        run(1'b0, 0, 0, 1'b0, "R3");
        chk(int'(y_o) == 38912, "R3 slope", int'(y_o), 38912);
        cur_x = '{327680, 0, 0, 0};
        run(1'b0, 0, 0, 1'b0, "R3");
        chk(int'(y_o) == 40960, "R3 high clamp", int'(y_o), 40960);
        load(0, 1966080000);
        load(16, 524288);
        cur_x = '{1966080000, 0, 0, 0};
        run(1'b0, 0, 0, 1'b0, "R1");
        chk(int'(y_o) == 65536, "R1 product clamp", int'(y_o), 65536);

        // R10 out-of-range address ignored
        load(25, 32'h0100_0000);
        run(1'b0, 0, 0, 1'b0, "R10 addr 25");

        // R7 R8 training then inference of the updated weights
        rand_weights();
        for (int n = 0; n < 24; n++) begin
            if (n % 8 == 7) rand_weights();
            rand_x();
            run(1'b1, ($urandom_range(0, 1) != 0) ? 65536 : 0, int'($urandom_range(0, 7)), 1'b0, "R6");
            run(1'b0, 0, 0, 1'b0, "R7 R8 updated weights");
        end
        // R8 extremes of the shift
        rand_x();
        run(1'b1, 65536, 0, 1'b0, "R8 shift 0");
        run(1'b1, 0, 15, 1'b0, "R8 shift 15");
        run(1'b0, 0, 0, 1'b0, "R8 after");

        // R9 R10 start and load while busy are ignored
        rand_x();
        run(1'b1, 65536, 2, 1'b1, "R9 disturbed");
        run(1'b0, 0, 0, 1'b0, "R10 busy load ignored");
        run(1'b0, 0, 0, 1'b1, "R9 disturbed inference");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule